// File: doc/BRIEF.md
# Vector Mask Compress and Expand Unit

This block packs and unpacks the elements of a vector register under a per-element select mask. In compress mode it walks the source vector from the lowest index upward and copies every element whose mask bit is set into the next free slot of the destination, starting at slot 0. It also reports how many elements it kept. In expand mode it does the opposite. It walks the destination positions upward and gives each position whose mask bit is set the next unread element of the packed source. Each position whose mask bit is clear takes the element at the same index of a background vector.

A request is made by pulsing `start` while the unit is idle. The operands are captured on that edge, and the unit then handles one element per clock. When the last element is done, `done` pulses for one cycle. The result and the kept-element count then stay unchanged until the next accepted request. The element width and the maximum vector length are parameters.

Top module: `vec_pack_unit`

## Requirements
- R1: Compress (`op`=0) writes the source elements whose mask bit is 1 into destination slots 0, 1, 2, ... in ascending source index order. For example, with 8 elements and mask 8'b1011_0010, slots 0..3 hold source elements 1, 4, 5, 7.
- R2: When `done` is high, `packed_len` equals the number of mask bits set at indices below the effective vector length. This holds for both operations.
- R3: After a compress, every destination slot from `packed_len` upward holds zero, including slots at or above the vector length.
- R4: Expand (`op`=1) places packed source element k at the position of the k-th set mask bit, counted from index 0.
- R5: After an expand, positions below the vector length whose mask bit is 0 hold the background element of the same index, and positions at or above the vector length hold zero.
- R6: Mask bits at indices at or above the effective vector length have no effect on `result` or `packed_len`.
- R7: `done` is high for exactly one cycle. It rises max(L,1) clock edges after the edge that samples `start`, where L is the effective vector length, so one element is handled per clock.
- R8: A `start` pulse that arrives while `busy` is high is ignored. The operation in flight completes with its original operands.
- R9: While idle, `result` and `packed_len` hold their values until the next accepted `start`.
- R10: A `vlen` value above MAX_VL is treated as MAX_VL. A `vlen` of 0 yields an all-zero result and `packed_len` of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, accepted only when idle |
| op | input | 1 | 0 = compress, 1 = expand |
| vlen | input | $clog2(MAX_VL+1) | Requested vector length |
| mask | input | MAX_VL | Per-element select bits, bit i belongs to element i |
| src_vec | input | MAX_VL*ELEM_W | Source vector, element i at bits [i*ELEM_W +: ELEM_W] |
| bg_vec | input | MAX_VL*ELEM_W | Background vector for expand |
| result | output | MAX_VL*ELEM_W | Destination vector |
| packed_len | output | $clog2(MAX_VL+1) | Count of selected elements |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the unit with ELEM_W=16 and MAX_VL=8, so the length field is 4 bits wide. This size puts the full-length case, the worked 8-element mask example, and lengths 9 to 15 (which exercise the clamp) within a few cycles each. A scoreboard queues the values predicted for every accepted request and compares them against the result, the count and the completion latency when `done` fires. Random masks and lengths at this small size reach the empty, full and sparse patterns many times.

// File: rtl/vpk_pkg.sv
package vpk_pkg;
   typedef enum logic {
      VPK_COMPRESS = 1'b0,
      VPK_EXPAND   = 1'b1
   } vpk_op_e;
endpackage

// File: rtl/vpk_pick.sv
// Selects one element out of a flat vector by index.
module vpk_pick #(
   parameter int ELEM_W = 64,
   parameter int MAX_VL = 64,
   parameter bit AND_OR = 1'b0,
   localparam int IDX_W = $clog2(MAX_VL)
) (
   input  logic [MAX_VL*ELEM_W-1:0] vec,
   input  logic [IDX_W-1:0]         sel,
   output logic [ELEM_W-1:0]        elem
);
   generate
      if (AND_OR) begin : g_andor
         logic [ELEM_W-1:0] terms [MAX_VL];
         for (genvar e = 0; e < MAX_VL; e++) begin : g_term
            assign terms[e] = (sel == IDX_W'(e)) ? vec[e*ELEM_W +: ELEM_W] : '0;
         end
         always_comb begin
            elem = '0;
            for (int e = 0; e < MAX_VL; e++) elem = elem | terms[e];
         end
      end else begin : g_index
         assign elem = vec[sel*ELEM_W +: ELEM_W];
      end
   endgenerate
endmodule

// File: rtl/vpk_ctrl.sv
// Sequencer: accepts a request, steps the element index, pulses done.
module vpk_ctrl #(
   parameter int MAX_VL = 64,
   localparam int CNT_W = $clog2(MAX_VL + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] vlen_in,
   output logic             accept,
   output logic             step,
   output logic             busy,
   output logic             done,
   output logic [CNT_W-1:0] idx,
   output logic [CNT_W-1:0] vl_q
);
   localparam int EXT_W = CNT_W + 1;

   logic [CNT_W-1:0] vl_eff;
   logic             last;

   assign vl_eff = (vlen_in > CNT_W'(MAX_VL)) ? CNT_W'(MAX_VL) : vlen_in;
   assign accept = start && !busy;
   assign step   = busy && (idx < vl_q);
   assign last   = ({1'b0, idx} + EXT_W'(1)) >= {1'b0, vl_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         done <= 1'b0;
         idx  <= '0;
         vl_q <= '0;
      end else begin
         done <= 1'b0;
         if (accept) begin
            busy <= 1'b1;
            idx  <= '0;
            vl_q <= vl_eff;
         end else if (busy) begin
            idx <= idx + CNT_W'(1);
            if (last) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> $stable(vl_q));
   a_r10_len_clamped: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (vl_q <= CNT_W'(MAX_VL)));
endmodule

// File: rtl/vec_pack_unit.sv
module vec_pack_unit #(
   parameter int ELEM_W = 64,
   parameter int MAX_VL = 64,
   parameter bit AND_OR = 1'b0
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           start,
   input  logic                           op,
   input  logic [$clog2(MAX_VL+1)-1:0]    vlen,
   input  logic [MAX_VL-1:0]              mask,
   input  logic [MAX_VL*ELEM_W-1:0]       src_vec,
   input  logic [MAX_VL*ELEM_W-1:0]       bg_vec,
   output logic [MAX_VL*ELEM_W-1:0]       result,
   output logic [$clog2(MAX_VL+1)-1:0]    packed_len,
   output logic                           busy,
   output logic                           done
);
   import vpk_pkg::*;

   localparam int CNT_W = $clog2(MAX_VL + 1);
   localparam int IDX_W = $clog2(MAX_VL);
   localparam int FLAT_W = MAX_VL * ELEM_W;

   generate
      if (ELEM_W < 1) begin : g_bad_w
         $error("vec_pack_unit: ELEM_W must be at least 1");
      end
      if (MAX_VL < 2) begin : g_bad_vl
         $error("vec_pack_unit: MAX_VL must be at least 2");
      end
   endgenerate

   logic              accept, step;
   logic [CNT_W-1:0]  idx, vl_q, cnt;
   logic [FLAT_W-1:0] src_q, bg_q, res_q;
   logic [MAX_VL-1:0] mask_q;
   vpk_op_e           op_q;
   logic [IDX_W-1:0]  idx_s, cnt_s, wpos;
   logic [ELEM_W-1:0] src_at_idx, src_at_cnt, bg_at_idx, wdata;
   logic              sel_bit, wen;

   vpk_ctrl #(.MAX_VL(MAX_VL)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .vlen_in(vlen),
      .accept(accept), .step(step), .busy(busy), .done(done),
      .idx(idx), .vl_q(vl_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q  <= '0;
         bg_q   <= '0;
         mask_q <= '0;
         op_q   <= VPK_COMPRESS;
      end else if (accept) begin
         src_q  <= src_vec;
         bg_q   <= bg_vec;
         mask_q <= mask;
         op_q   <= vpk_op_e'(op);
      end
   end

   assign idx_s   = idx[IDX_W-1:0];
   assign cnt_s   = cnt[IDX_W-1:0];
   assign sel_bit = mask_q[idx_s];

   vpk_pick #(.ELEM_W(ELEM_W), .MAX_VL(MAX_VL), .AND_OR(AND_OR)) u_pick_si (
      .vec(src_q), .sel(idx_s), .elem(src_at_idx));
   vpk_pick #(.ELEM_W(ELEM_W), .MAX_VL(MAX_VL), .AND_OR(AND_OR)) u_pick_sc (
      .vec(src_q), .sel(cnt_s), .elem(src_at_cnt));
   vpk_pick #(.ELEM_W(ELEM_W), .MAX_VL(MAX_VL), .AND_OR(AND_OR)) u_pick_bg (
      .vec(bg_q), .sel(idx_s), .elem(bg_at_idx));

   // Compress writes at the running count; expand writes in place.
   always_comb begin
      if (op_q == VPK_COMPRESS) begin
         wpos  = cnt_s;
         wdata = src_at_idx;
         wen   = step && sel_bit;
      end else begin
         wpos  = idx_s;
         wdata = sel_bit ? src_at_cnt : bg_at_idx;
         wen   = step;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt <= '0;
      else if (accept)           cnt <= '0;
      else if (step && sel_bit)  cnt <= cnt + CNT_W'(1);
   end

   generate
      for (genvar e = 0; e < MAX_VL; e++) begin : g_dst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               res_q[e*ELEM_W +: ELEM_W] <= '0;
            else if (accept)
               res_q[e*ELEM_W +: ELEM_W] <= '0;
            else if (wen && (wpos == IDX_W'(e)))
               res_q[e*ELEM_W +: ELEM_W] <= wdata;
         end
      end
   endgenerate

   assign result     = res_q;
   assign packed_len = cnt;

   a_r1_count_trails_index: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cnt <= idx));
   a_r2_len_within_vl: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (packed_len <= vl_q));
   a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(result) && $stable(packed_len)));
endmodule

// File: tb/sim_vec_pack_unit.sv
`timescale 1ns/1ps
module sim_vec_pack_unit;
   localparam int EW = 16;
   localparam int VL = 8;
   localparam int CW = $clog2(VL + 1);
   localparam int FW = EW * VL;

   typedef struct {
      logic [FW-1:0] res;
      int            len;
      int            t0;
      int            lat;
      string         tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          op = 1'b0;
   logic [CW-1:0] vlen = '0;
   logic [VL-1:0] mask = '0;
   logic [FW-1:0] src_vec = '0, bg_vec = '0;
   logic [FW-1:0] result;
   logic [CW-1:0] packed_len;
   logic          busy, done;

   int   errors = 0, checks = 0, cyc = 0;
   bit   finished = 0;
   exp_t sb[$];
   logic [FW-1:0] last_res;
   int   last_len;

   vec_pack_unit #(.ELEM_W(EW), .MAX_VL(VL)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .vlen(vlen),
      .mask(mask), .src_vec(src_vec), .bg_vec(bg_vec), .result(result),
      .packed_len(packed_len), .busy(busy), .done(done));

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [FW-1:0] act, input logic [FW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic void model(input logic o, input logic [FW-1:0] s,
         input logic [FW-1:0] b, input logic [VL-1:0] m, input int v,
         output logic [FW-1:0] r, output int n);
      int eff;
      eff = (v > VL) ? VL : v;
      r = '0; n = 0;
      for (int i = 0; i < eff; i++) begin
         if (!o) begin
            if (m[i]) begin r[n*EW +: EW] = s[i*EW +: EW]; n++; end
         end else begin
            if (m[i]) begin r[i*EW +: EW] = s[n*EW +: EW]; n++; end
            else r[i*EW +: EW] = b[i*EW +: EW];
         end
      end
   endfunction

   // Driver: presents one request and queues its prediction.
   task automatic launch(input logic o, input logic [FW-1:0] s,
         input logic [FW-1:0] b, input logic [VL-1:0] m, input int v,
         input string tag);
      exp_t e;
      int eff;
      @(negedge clk);
      op = o; src_vec = s; bg_vec = b; mask = m; vlen = CW'(v); start = 1'b1;
      model(o, s, b, m, v, e.res, e.len);
      eff = (v > VL) ? VL : v;
      e.t0 = cyc; e.lat = ((eff < 1) ? 1 : eff) + 1; e.tag = tag;
      sb.push_back(e);
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic drain();
      while (sb.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   // Monitor: compares each completion against the queue head.
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (sb.size() == 0) begin
            check(1'b0, "R8", "unexpected done", '0, '0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(result == e.res, "R1/R3/R4/R5/R6", {e.tag, " result"}, result, e.res);
            check(int'(packed_len) == e.len, "R2", {e.tag, " packed_len"},
                  FW'(packed_len), FW'(e.len));
            check(cyc - e.t0 == e.lat, "R7", {e.tag, " latency"},
                  FW'(cyc - e.t0), FW'(e.lat));
            last_res = result; last_len = int'(packed_len);
         end
      end
      if (rst_n && done) begin
         @(negedge clk);
         check(!done, "R7", "done width", FW'(done), '0);
      end
   end

   function automatic logic [FW-1:0] ramp(input logic [EW-1:0] base);
      logic [FW-1:0] r;
      for (int i = 0; i < VL; i++) r[i*EW +: EW] = base + EW'(i);
      return r;
   endfunction

   function automatic logic [FW-1:0] rnd_vec();
      logic [FW-1:0] r;
      for (int i = 0; i < VL; i++) r[i*EW +: EW] = EW'($urandom);
      return r;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [FW-1:0] a, z;
      repeat (3) @(negedge clk);
      check(result == '0 && packed_len == '0 && !busy && !done, "R9",
            "reset state", result, '0);
      rst_n = 1'b1;
      a = ramp(16'hA000);
      z = ramp(16'hB000);

      // R1: worked example, mask 1011_0010 over 8 elements
      launch(1'b0, a, z, 8'b1011_0010, 8, "R1 example compress");
      drain();
      check(result[0*EW +: EW] == 16'hA001, "R1", "slot0 is element 1",
            FW'(result[0 +: EW]), FW'(16'hA001));
      check(result[3*EW +: EW] == 16'hA007, "R1", "slot3 is element 7",
            FW'(result[3*EW +: EW]), FW'(16'hA007));
      check(result[4*EW +: EW] == '0, "R3", "slot4 zero",
            FW'(result[4*EW +: EW]), '0);

      // R4 R5: expand with the same mask
      launch(1'b1, a, z, 8'b1011_0010, 8, "R4 R5 example expand");
      drain();
      check(result[1*EW +: EW] == 16'hA000 && result[7*EW +: EW] == 16'hA003,
            "R4", "packed 0 at pos1, packed 3 at pos7", result, '0);

      // R6: mask bits above vlen ignored
      launch(1'b0, a, z, 8'b1111_1111, 5, "R6 compress vl5");
      drain();
      launch(1'b1, a, z, 8'b1110_0101, 3, "R6 expand vl3");
      drain();
      // R3: empty mask, R10: zero and clamped lengths
      launch(1'b0, a, z, 8'b0000_0000, 8, "R3 empty mask");
      drain();
      launch(1'b1, a, z, 8'b0101_0101, 0, "R10 vlen zero");
      drain();
      launch(1'b0, a, z, 8'b1100_1001, 15, "R10 vlen clamp");
      drain();

      // R8: second start during busy is dropped
      launch(1'b0, a, z, 8'b0110_0110, 8, "R8 first op");
      @(negedge clk);
      op = 1'b1; mask = 8'hFF; vlen = CW'(2); src_vec = z; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      drain();

      // R9: outputs hold while idle
      repeat (4) @(negedge clk);
      check(result == last_res && int'(packed_len) == last_len, "R9",
            "idle hold", result, last_res);

      for (int k = 0; k < 30; k++) begin
         launch(1'($urandom), rnd_vec(), rnd_vec(), VL'($urandom),
                int'($urandom_range(0, 15)), "random");
         drain();
      end

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule